// File: doc/BRIEF.md
# Frame Pulse Offset Meter

The block measures how far a frame pulse under test lags the local reference frame pulse, counted in master clock periods. The reference pulse and the pulse under test are both active low and one clock wide. Which stream's pulse is applied to the test input is decided outside the block. A processor controls the block with a single start bit and reads back a completion flag and a 12-bit offset.

Before a measurement can begin, the start bit must be held low for one whole reference frame. After that, a low-to-high change of the start bit arms the block. The first reference frame boundary after arming opens the measurement window. The next boundary closes it and publishes the result.

The offset counts master clocks from the opening boundary to the first test pulse inside the window. The count stops at the largest 12-bit value. A window with no test pulse reports all ones. The flag and the result stay where they are until the processor clears the start bit. A new measurement needs a fresh qualification: a full frame with the start bit low, then another rising edge.

Top module: `frame_offset_meter`

## Requirements
- R1: While reset is asserted and after it is released, done_o is 0 and offset_o is 0. The block then waits for the start bit to be low through a full frame.
- R2: A rising edge of start_i arms the block only if start_i was sampled low at two consecutive reference boundaries and stayed low between them. A boundary is a clock on which ref_fp_ni is sampled 0. A rising edge without this qualification starts no measurement.
- R3: After arming, the first boundary opens the window and the second boundary closes it. done_o goes from 0 to 1 on the clock edge that samples the closing boundary, so it reads 1 one clock after that boundary is driven.
- R4: offset_o equals the number of clocks from the opening boundary to the first clock in the window on which test_fp_ni is sampled 0. A test pulse on the boundary clock itself gives 0.
- R5: Only the first test pulse inside the window sets the result. Later pulses in the same window are ignored.
- R6: If no test pulse is sampled during the window, offset_o becomes 4095 (all ones).
- R7: An offset beyond 4095 clocks saturates at 4095. An offset of 4094 is reported exactly.
- R8: Sampling start_i low clears done_o on the next edge. offset_o keeps its last value and changes only on the edge where done_o rises.
- R9: While start_i stays high after completion, done_o stays 1, offset_o is unchanged, and no new measurement is taken.
- R10: Clearing start_i before the window closes abandons the measurement. done_o does not rise and offset_o keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| ref_fp_ni | input | 1 | Reference frame pulse, active low, one clock wide |
| test_fp_ni | input | 1 | Frame pulse under test, active low |
| start_i | input | 1 | Start control bit from the processor |
| done_o | output | 1 | Measurement complete flag |
| offset_o | output | 12 | Measured offset in master clocks |

## Verification
A wrong qualification or arming state shows up as done_o rising when it should not, or never rising. This becomes visible within two or three reference frames of the start edge. A wrong window state or a wrong position count shows up as the wrong offset_o value, or as done_o rising one frame early or late. The scoreboard catches this on the very edge where done_o rises. A failure to hold or clear shows up one clock after start_i changes, or during the frames that follow completion.

// File: rtl/fpm_pkg.sv
package fpm_pkg;
  localparam int OFS_W = 12;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SYNC = 2'd1,
    ST_MEAS = 2'd2,
    ST_DONE = 2'd3
  } fpm_state_e;

  // Saturating increment: stays at all ones once reached.
  function automatic logic [OFS_W-1:0] sat_inc(input logic [OFS_W-1:0] v);
    return (&v) ? v : v + 1'b1;
  endfunction

  // Result published at window close: captured count, or all ones if nothing seen.
  function automatic logic [OFS_W-1:0] pick_result(input logic seen,
                                                   input logic [OFS_W-1:0] cap);
    return seen ? cap : {OFS_W{1'b1}};
  endfunction
endpackage

// File: rtl/fpm_arm_qual.sv
module fpm_arm_qual (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic frame_ev_i,
  input  logic start_i,
  output logic arm_o
);
  logic start_d_q;
  logic low_run_q;
  logic qual_q;

  // Rising edge of the start bit, accepted only after a qualified low frame.
  assign arm_o = start_i & ~start_d_q & qual_q;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      start_d_q <= 1'b1;
      low_run_q <= 1'b0;
      qual_q    <= 1'b0;
    end else begin
      start_d_q <= start_i;
      if (start_i) begin
        low_run_q <= 1'b0;
        qual_q    <= 1'b0;
      end else if (frame_ev_i) begin
        low_run_q <= 1'b1;
        if (low_run_q) qual_q <= 1'b1;
      end
    end
  end

  AST_QUAL_NEEDS_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    qual_q |-> !start_d_q); // R2
endmodule

// File: rtl/fpm_pos_counter.sv
module fpm_pos_counter #(
  parameter int OFS_W = fpm_pkg::OFS_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             frame_ev_i,
  output logic [OFS_W-1:0] pos_o
);
  import fpm_pkg::*;

  logic [OFS_W-1:0] pos_q;

  // Position of the current clock relative to the latest boundary.
  assign pos_o = frame_ev_i ? '0 : pos_q;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) pos_q <= '0;
    else         pos_q <= sat_inc(pos_o);
  end

  AST_POS_SATURATES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((&pos_q) && !frame_ev_i) |=> (&pos_q)); // R7
  AST_POS_AFTER_BOUNDARY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_ev_i |=> (frame_ev_i || pos_o == OFS_W'(1))); // R4
endmodule

// File: rtl/fpm_capture.sv
module fpm_capture #(
  parameter int OFS_W = fpm_pkg::OFS_W
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                frame_ev_i,
  input  logic                test_ev_i,
  input  logic                start_i,
  input  logic                arm_i,
  input  logic [OFS_W-1:0]    pos_i,
  output logic                done_o,
  output logic [OFS_W-1:0]    offset_o,
  output fpm_pkg::fpm_state_e state_o
);
  import fpm_pkg::*;

  fpm_state_e       state_q;
  logic             seen_q;
  logic [OFS_W-1:0] cap_q;
  logic             done_q;
  logic [OFS_W-1:0] offset_q;

  assign done_o   = done_q;
  assign offset_o = offset_q;
  assign state_o  = state_q;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      seen_q   <= 1'b0;
      cap_q    <= '0;
      done_q   <= 1'b0;
      offset_q <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (arm_i) state_q <= ST_SYNC;
        ST_SYNC: begin
          if (!start_i) state_q <= ST_IDLE;
          else if (frame_ev_i) begin
            state_q <= ST_MEAS;
            seen_q  <= test_ev_i;
            cap_q   <= pos_i;
          end
        end
        ST_MEAS: begin
          if (!start_i) state_q <= ST_IDLE;
          else if (frame_ev_i) begin
            state_q  <= ST_DONE;
            done_q   <= 1'b1;
            offset_q <= pick_result(seen_q, cap_q);
          end else if (test_ev_i && !seen_q) begin
            seen_q <= 1'b1;
            cap_q  <= pos_i;
          end
        end
        default: begin
          if (!start_i) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b0;
          end
        end
      endcase
    end
  end

  AST_DONE_AT_BOUNDARY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_q) |-> $past(frame_ev_i)); // R3
  AST_DONE_NEEDS_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> !done_q); // R8
  AST_OFFSET_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$rose(done_q) |-> $stable(offset_q)); // R8
endmodule

// File: rtl/frame_offset_meter.sv
module frame_offset_meter #(
  parameter int OFS_W = fpm_pkg::OFS_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ref_fp_ni,
  input  logic             test_fp_ni,
  input  logic             start_i,
  output logic             done_o,
  output logic [OFS_W-1:0] offset_o
);
  import fpm_pkg::*;

  logic             frame_ev;
  logic             test_ev;
  logic             arm_ev;
  logic [OFS_W-1:0] pos;
  fpm_state_e       state;

  assign frame_ev = ~ref_fp_ni;
  assign test_ev  = ~test_fp_ni;

  fpm_arm_qual u_arm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .frame_ev_i (frame_ev),
    .start_i    (start_i),
    .arm_o      (arm_ev)
  );

  fpm_pos_counter #(.OFS_W(OFS_W)) u_pos (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .frame_ev_i (frame_ev),
    .pos_o      (pos)
  );

  fpm_capture #(.OFS_W(OFS_W)) u_cap (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .frame_ev_i (frame_ev),
    .test_ev_i  (test_ev),
    .start_i    (start_i),
    .arm_i      (arm_ev),
    .pos_i      (pos),
    .done_o     (done_o),
    .offset_o   (offset_o),
    .state_o    (state)
  );

  AST_ARM_IN_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arm_ev |-> (state == ST_IDLE)); // R2
endmodule

// File: tb/frame_offset_meter_tb_top.sv
module frame_offset_meter_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ref_fp_n = 1'b1;
  logic        test_fp_n = 1'b1;
  logic        start = 1'b0;
  logic        done;
  logic [11:0] offset;

  int checks = 0;
  int errors = 0;
  int exp_q[$];
  logic done_prev = 1'b0;

  always #2 clk = ~clk;

  frame_offset_meter dut_i (
    .clk_i(clk), .rst_ni(rst_n), .ref_fp_ni(ref_fp_n), .test_fp_ni(test_fp_n),
    .start_i(start), .done_o(done), .offset_o(offset)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Scoreboard monitor: on each rise of done, pop and compare the expected offset.
  always @(negedge clk) begin
    if (rst_n && done && !done_prev) begin
      if (exp_q.size() == 0) chk(1'b0, "R2 unexpected completion", 1, 0);
      else begin
        int e;
        e = exp_q.pop_front();
        chk(offset == 12'(e), "R4/R5/R6/R7 offset", int'(offset), e);
      end
    end
    done_prev = done;
  end

  // One reference frame; test pulses at p1/p2, start dropped at index drop.
  task automatic frame(input int len, input int p1, input int p2, input int drop);
    for (int i = 0; i < len; i++) begin
      ref_fp_n  = (i == 0) ? 1'b0 : 1'b1;
      test_fp_n = (i == p1 || i == p2) ? 1'b0 : 1'b1;
      if (i == drop) start = 1'b0;
      @(negedge clk);
    end
    ref_fp_n  = 1'b1;
    test_fp_n = 1'b1;
  endtask

  // Driver: qualify, arm, run the window, push expected result, close the window.
  task automatic measure(input int p1, input int p2, input int len);
    int e;
    e = (p1 < 0) ? 4095 : ((p1 > 4095) ? 4095 : p1);
    start = 1'b0;
    repeat (3) frame(20, -1, -1, -1);
    start = 1'b1;
    @(negedge clk);
    exp_q.push_back(e);
    frame(len, p1, p2, -1);
    chk(done == 1'b0, "R3 done before closing boundary", int'(done), 0);
    ref_fp_n = 1'b0;
    @(negedge clk);
    ref_fp_n = 1'b1;
    chk(done == 1'b1, "R3 done after closing boundary", int'(done), 1);
    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0, "R3 result delivered", exp_q.size(), 0);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    chk(done == 1'b0 && offset == 12'd0, "R1 reset state", int'(offset), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(done == 1'b0 && offset == 12'd0, "R1 after release", int'(offset), 0);

    measure(7, -1, 20);     // R4
    measure(0, -1, 20);     // R4 coincident pulse
    measure(3, 11, 20);     // R5 first pulse wins
    measure(-1, -1, 20);    // R6 no pulse

    // R9: start held high after completion
    repeat (3) frame(20, 5, -1, -1);
    chk(done == 1'b1, "R9 done held", int'(done), 1);
    chk(offset == 12'd4095, "R9 offset held", int'(offset), 4095);

    // R8: clearing start clears done, offset held
    start = 1'b0;
    @(negedge clk);
    chk(done == 1'b0, "R8 done cleared", int'(done), 0);
    chk(offset == 12'd4095, "R8 offset held", int'(offset), 4095);

    // R2: rising edge with no boundary while low
    start = 1'b1;
    repeat (3) frame(20, 5, -1, -1);
    chk(done == 1'b0, "R2 no arm without low frame", int'(done), 0);
    // R2: low across only one boundary
    start = 1'b0;
    frame(20, -1, -1, -1);
    start = 1'b1;
    repeat (3) frame(20, 5, -1, -1);
    chk(done == 1'b0, "R2 no arm after partial low frame", int'(done), 0);
    chk(offset == 12'd4095, "R2 offset untouched", int'(offset), 4095);

    measure(4094, -1, 5000); // R7 largest exact value
    measure(4500, -1, 5000); // R7 saturation

    // R10: abort inside the window
    start = 1'b0;
    repeat (3) frame(20, -1, -1, -1);
    start = 1'b1;
    @(negedge clk);
    frame(20, 3, -1, 10);
    repeat (3) frame(20, 6, -1, -1);
    chk(done == 1'b0, "R10 no done after abort", int'(done), 0);
    chk(offset == 12'd4095, "R10 offset kept", int'(offset), 4095);

    measure(12, -1, 30);    // R3 re-arm after abort

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule